// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block stands in for the embedded controller of a byte-wide NOR flash. A command decoder upstream hands it either a single-byte program request or a whole-array erase request. The block then runs the operation for a programmable number of clock cycles and updates a small internal cell array. While it is working, every bus read returns a status byte instead of array data. The status byte has three parts: a polling bit derived from the operation, a bit that flips on each status read, and a sticky error bit. The engine signals a clean finish, a failure and a completed abort.

Programming follows flash cell rules, so it can only clear bits. The stored byte becomes the old byte ANDed with the requested byte. A request that asks for a 1 where the cell already holds 0 is treated as a failure. A test input can also force a failure. After a failure the engine keeps returning status until a reset command arrives. A reset command given during an erase aborts it after a fixed delay. A program, once started, ignores every command until it ends.

Top module: `pe_status_engine`

## Requirements
- R1: After power-up every cell reads 8'hFF. With reset low, the engine is idle (busy, done, aborted and err_flag all 0), and a read in idle returns the addressed cell on rd_data in the cycle after rd_en.
- R2: In any non-idle state, a read at any address returns the status byte. Bits 4:0 of the status byte are 0.
- R3: Status bit 7 is the inverse of bit 7 of the byte being programmed during a program and its error state. It is 0 during an erase, an abort and the error state after an erase.
- R4: Status bit 6 reads 0 on the first status read after an operation starts, and it inverts on every following status read, including reads in the error state.
- R5: A program keeps busy high for exactly PROG_CYCLES cycles. It stores the old byte ANDed with the new byte and, on success, pulses done for one cycle as busy falls.
- R6: A program whose data has a 1 over a stored 0, or any operation started with fail_inject high, ends in the error state. In that state err_flag is 1, status bit 5 is 1, done stays 0, and start requests are ignored.
- R7: A reset_cmd in the error state returns the engine to idle read mode with err_flag cleared.
- R8: A chip erase keeps busy high for ERASE_CYCLES + 2^ADDR_W cycles. It then pulses done, and every cell reads 8'hFF.
- R9: While a program runs, start_prog, start_erase and reset_cmd have no effect on its duration, its target cell or any other cell.
- R10: A reset_cmd during an erase (wait or write phase) ends the erase after ABORT_CYCLES further busy cycles. The end is marked by a one-cycle aborted pulse with no done and no error, and reads during the abort return status.
- R11: In idle, reset_cmd does nothing. When start_prog and start_erase arrive together, the program is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_prog | input | 1 | Start a single-byte program (sampled in idle) |
| start_erase | input | 1 | Start a whole-array erase (sampled in idle) |
| reset_cmd | input | 1 | Read/reset command: clears error, aborts erase |
| fail_inject | input | 1 | Forces the operation being started to fail |
| op_addr | input | ADDR_W | Program target address |
| op_data | input | DATA_W | Program data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read address |
| rd_data | output | DATA_W | Read result, valid the cycle after rd_en |
| busy | output | 1 | Program, erase or abort in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| aborted | output | 1 | One-cycle pulse when an erase abort finishes |
| err_flag | output | 1 | Error state held until reset_cmd |

## Verification
The bench builds the engine with a 16-cell array of bytes, a 4-cycle program, a 6-cycle erase wait and a 5-cycle abort delay. These sizes keep the runs short enough to program every address twice, to read back the whole array after each phase and to read status on every cycle of a program. The second pass over all addresses uses arithmetic data patterns that mix clean AND-updates with illegal 0-to-1 requests. This brings both outcome paths, and the toggle sequence in the error state, within reach at every cell. The short erase lets aborts be placed in both the wait phase and the write sweep, and lets a forced erase failure run through to a full readback.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SWEEP = 3'd3,
    ST_ABORT = 3'd4,
    ST_FAULT = 3'd5
  } pe_state_t;

  localparam int STAT_FLAGS = 3;
endpackage

// File: rtl/pe_cell_array.sv
module pe_cell_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // cells leave the factory erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  // one write port, one registered read port, read-first
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pe_op_timer.sv
module pe_op_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // a running count steps down by one each cycle (durations of R5, R8, R10)
  assert_timer_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              rd_take,
  input  logic              poll_bit,
  input  logic              err_bit,
  output logic [DATA_W-1:0] stat_q
);
  localparam int LOW_W = DATA_W - pe_pkg::STAT_FLAGS;

  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      if (clear)        tog_q <= 1'b0;
      else if (rd_take) tog_q <= ~tog_q;
      if (rd_take) stat_q <= {poll_bit, tog_q, err_bit, {LOW_W{1'b0}}};
    end
  end

  // the toggle only moves on a status read or an operation start
  assert_toggle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!rd_take && !clear) |=> $stable(tog_q));
endmodule

// File: rtl/pe_status_engine.sv
module pe_status_engine
  import pe_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 6,
  parameter int ABORT_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              reset_cmd,
  input  logic              fail_inject,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic              err_flag
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int MAX_A   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int MAX_CYC = (MAX_A > ABORT_CYCLES) ? MAX_A : ABORT_CYCLES;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  pe_state_t         state_q, state_d;
  logic [ADDR_W-1:0] paddr_q, sweep_q;
  logic [DATA_W-1:0] pdata_q;
  logic              is_prog_q, fail_q, sel_q, done_q, abort_q;

  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;

  logic              arr_we, arr_re;
  logic [ADDR_W-1:0] arr_waddr, arr_raddr;
  logic [DATA_W-1:0] arr_wdata, arr_q, stat_q;

  logic stat_mode, rd_take, op_start, prog_fail, finish_ok;

  assign stat_mode = (state_q != ST_READ);
  assign rd_take   = rd_en & stat_mode;
  // while not idle the read port fetches the program target for the AND update
  assign arr_raddr = stat_mode ? paddr_q : rd_addr;
  assign arr_re    = rd_en | stat_mode;
  assign prog_fail = fail_q | (|(pdata_q & ~arr_q));

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    arr_we    = 1'b0;
    arr_waddr = paddr_q;
    arr_wdata = arr_q & pdata_q;
    op_start  = 1'b0;
    finish_ok = 1'b0;
    unique case (state_q)
      ST_READ: begin
        if (start_prog) begin
          state_d  = ST_PROG;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(PROG_CYCLES - 1);
          op_start = 1'b1;
        end else if (start_erase) begin
          state_d  = ST_ERASE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(ERASE_CYCLES - 1);
          op_start = 1'b1;
        end
      end
      ST_PROG: begin
        if (tmr_zero) begin
          arr_we = 1'b1;
          if (prog_fail) state_d = ST_FAULT;
          else begin
            state_d   = ST_READ;
            finish_ok = 1'b1;
          end
        end
      end
      ST_ERASE: begin
        if (reset_cmd) begin
          state_d  = ST_ABORT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(ABORT_CYCLES - 1);
        end else if (tmr_zero) begin
          state_d = ST_SWEEP;
        end
      end
      ST_SWEEP: begin
        arr_we    = 1'b1;
        arr_waddr = sweep_q;
        arr_wdata = '1;
        if (reset_cmd) begin
          state_d  = ST_ABORT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(ABORT_CYCLES - 1);
        end else if (sweep_q == LAST_ADDR) begin
          if (fail_q) state_d = ST_FAULT;
          else begin
            state_d   = ST_READ;
            finish_ok = 1'b1;
          end
        end
      end
      ST_ABORT: begin
        if (tmr_zero) state_d = ST_READ;
      end
      ST_FAULT: begin
        if (reset_cmd) state_d = ST_READ;
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_READ;
      paddr_q   <= '0;
      pdata_q   <= '0;
      is_prog_q <= 1'b0;
      fail_q    <= 1'b0;
      sel_q     <= 1'b0;
      done_q    <= 1'b0;
      abort_q   <= 1'b0;
      sweep_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish_ok;
      abort_q <= (state_q == ST_ABORT) && tmr_zero;
      if (rd_en) sel_q <= stat_mode;
      if (state_q == ST_SWEEP) sweep_q <= sweep_q + 1'b1;
      else                     sweep_q <= '0;
      if (op_start) begin
        paddr_q   <= op_addr;
        pdata_q   <= op_data;
        is_prog_q <= start_prog;
        fail_q    <= fail_inject;
      end
    end
  end

  pe_op_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  pe_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .re    (arr_re),
    .raddr (arr_raddr),
    .rdata (arr_q)
  );

  pe_status_gen #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .clear    (op_start),
    .rd_take  (rd_take),
    .poll_bit (is_prog_q & ~pdata_q[DATA_W-1]),
    .err_bit  (state_q == ST_FAULT),
    .stat_q   (stat_q)
  );

  assign rd_data  = sel_q ? stat_q : arr_q;
  assign busy     = (state_q == ST_PROG) || (state_q == ST_ERASE) ||
                    (state_q == ST_SWEEP) || (state_q == ST_ABORT);
  assign err_flag = (state_q == ST_FAULT);
  assign done     = done_q;
  assign aborted  = abort_q;

  // a running program is never cut short
  assert_prog_uninterrupted_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PROG && !tmr_zero) |=> (state_q == ST_PROG));

  // the error state is left only through reset_cmd
  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !reset_cmd) |=> err_flag);

  // erase and abort reads show a cleared polling bit
  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (state_q == ST_ERASE || state_q == ST_SWEEP || state_q == ST_ABORT))
      |=> (rd_data[DATA_W-1] == 1'b0));

  // success is reported only once the engine is idle and clean
  assert_done_clean_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !err_flag));

  // completion and abort never coincide
  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, aborted}));
endmodule

// File: tb/tb_pe_status_engine.sv
module tb_pe_status_engine;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int PC = 4;
  localparam int EC = 6;
  localparam int AC = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, start_prog, start_erase, reset_cmd, fail_inject, rd_en;
  logic [AW-1:0] op_addr, rd_addr;
  logic [DW-1:0] op_data, rd_data;
  logic busy, done, aborted, err_flag;

  pe_status_engine #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC),
                     .ERASE_CYCLES(EC), .ABORT_CYCLES(AC)) dut (
    .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
    .reset_cmd(reset_cmd), .fail_inject(fail_inject), .op_addr(op_addr),
    .op_data(op_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .aborted(aborted), .err_flag(err_flag));

  int errors = 0;
  int checks = 0;
  logic [7:0] model [DEPTH];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input logic p, input logic t, input logic e);
    return {p, t, e, 5'b0};
  endfunction

  task automatic rd(input int a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic go_prog(input int a, input logic [7:0] d, input logic inj);
    start_prog = 1'b1; op_addr = AW'(a); op_data = d; fail_inject = inj;
    @(negedge clk);
    start_prog = 1'b0; fail_inject = 1'b0;
  endtask

  task automatic go_erase(input logic inj);
    start_erase = 1'b1; fail_inject = inj;
    @(negedge clk);
    start_erase = 1'b0; fail_inject = 1'b0;
  endtask

  task automatic go_reset;
    reset_cmd = 1'b1;
    @(negedge clk);
    reset_cmd = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sweep_check(input string tag);
    logic [7:0] v;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      chk(tag, v, model[a]);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [7:0] v, d;
    int n;
    logic fl;
    rst = 1'b1; start_prog = 0; start_erase = 0; reset_cmd = 0; fail_inject = 0;
    rd_en = 0; op_addr = '0; rd_addr = '0; op_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset err_flag", err_flag, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset aborted", aborted, 0);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    sweep_check("R1 erased at power-up");

    // pass 1: program every cell, reading status on every busy cycle
    for (int a = 0; a < DEPTH; a++) begin
      d = 8'((a * 37 + 11) & 255);
      go_prog(a, d, 1'b0);
      for (int k = 0; k < PC; k++) begin
        rd((a + k) % DEPTH, v);
        chk("R2 R3 R4 program status", v, st(~d[7], k[0], 1'b0));
      end
      chk("R5 busy low after program", busy, 0);
      chk("R5 done pulse", done, 1);
      model[a] = d;
    end
    sweep_check("R5 readback pass 1");

    // pass 2: AND update, illegal 0-to-1 requests go to error
    for (int a = 0; a < DEPTH; a++) begin
      d = 8'((a * 91 + 7) & 255);
      fl = |(d & ~model[a]);
      go_prog(a, d, 1'b0);
      wait_idle(n);
      chk("R5 program duration", n, PC);
      if (fl) begin
        chk("R6 err_flag set", err_flag, 1);
        chk("R6 no done on failure", done, 0);
        rd(a ^ 5, v);
        chk("R6 R3 error status", v, st(~d[7], 1'b0, 1'b1));
        go_prog((a + 1) % DEPTH, 8'h00, 1'b0);
        rd(a, v);
        chk("R6 R4 start ignored in error, toggle", v, st(~d[7], 1'b1, 1'b1));
        chk("R6 error held", err_flag, 1);
        go_reset();
        chk("R7 err_flag cleared", err_flag, 0);
        chk("R7 idle after reset", busy, 0);
      end else begin
        chk("R5 done on clean program", done, 1);
      end
      model[a] = model[a] & d;
      rd(a, v);
      chk("R5 R7 AND result", v, model[a]);
    end
    sweep_check("R6 readback pass 2");

    // forced failure with legal data
    go_prog(2, model[2], 1'b1);
    wait_idle(n);
    chk("R6 injected failure", err_flag, 1);
    rd(9, v);
    chk("R6 injected status", v, st(~model[2][7], 1'b0, 1'b1));
    go_reset();
    chk("R7 cleared after injected failure", err_flag, 0);
    rd(2, v);
    chk("R7 cell kept", v, model[2]);

    // commands during a program are ignored
    d = model[6] & 8'hF0;
    go_prog(6, d, 1'b0);
    start_prog = 1'b1; start_erase = 1'b1; reset_cmd = 1'b1;
    op_addr = AW'(7); op_data = 8'h00;
    @(negedge clk);
    start_prog = 1'b0; start_erase = 1'b0; reset_cmd = 1'b0;
    wait_idle(n);
    chk("R9 duration unchanged", n + 1, PC);
    chk("R9 done", done, 1);
    model[6] = d;
    rd(6, v);
    chk("R9 target cell", v, model[6]);
    rd(7, v);
    chk("R9 other cell untouched", v, model[7]);

    // idle reset and simultaneous starts
    go_reset();
    chk("R11 reset in idle busy", busy, 0);
    chk("R11 reset in idle err", err_flag, 0);
    rd(0, v);
    chk("R11 reset in idle data", v, model[0]);
    d = model[8] & 8'h0F;
    start_prog = 1'b1; start_erase = 1'b1; op_addr = AW'(8); op_data = d;
    @(negedge clk);
    start_prog = 1'b0; start_erase = 1'b0;
    wait_idle(n);
    chk("R11 program wins", n, PC);
    model[8] = d;
    rd(8, v);
    chk("R11 programmed cell", v, model[8]);
    rd(9, v);
    chk("R11 no erase", v, model[9]);

    // chip erase with status reads
    go_erase(1'b0);
    for (int k = 0; k < 3; k++) begin
      rd(k * 5, v);
      chk("R3 R4 erase status", v, st(1'b0, k[0], 1'b0));
    end
    wait_idle(n);
    chk("R8 erase duration", n + 3, EC + DEPTH);
    chk("R8 erase done", done, 1);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    sweep_check("R8 erased");

    // abort in the wait phase
    go_prog(0, 8'h12, 1'b0);
    wait_idle(n);
    go_erase(1'b0);
    @(negedge clk);
    go_reset();
    rd(4, v);
    chk("R10 status during abort", v, st(1'b0, 1'b0, 1'b0));
    wait_idle(n);
    chk("R10 abort duration", n + 1, AC);
    chk("R10 aborted pulse", aborted, 1);
    chk("R10 no done", done, 0);
    chk("R10 no error", err_flag, 0);

    // abort in the write sweep
    go_erase(1'b0);
    repeat (EC + 3) @(negedge clk);
    go_reset();
    wait_idle(n);
    chk("R10 sweep abort duration", n, AC);
    chk("R10 sweep aborted pulse", aborted, 1);
    chk("R10 sweep no error", err_flag, 0);

    // failing erase still clears the array
    go_erase(1'b1);
    wait_idle(n);
    chk("R8 failing erase duration", n, EC + DEPTH);
    chk("R6 erase failure flag", err_flag, 1);
    chk("R6 erase failure no done", done, 0);
    rd(3, v);
    chk("R6 R3 erase error status", v, st(1'b0, 1'b0, 1'b1));
    go_reset();
    chk("R7 cleared after erase failure", err_flag, 0);
    sweep_check("R8 array after failing erase");

    report();
    $finish;
  end
endmodule